// File: doc/BRIEF.md
# Two-Stage Pipelined Register Renamer

This block maps the architectural register names of a group of four instructions onto physical register names, spread over two clock stages. In the first stage it reads the alias table for every source and destination, compares each operand against the older destinations in its own group and in the group one stage ahead, and takes fresh physical names from a circular free list. In the second stage it writes the group's new mappings into the table and picks, for each operand, the name it must finally carry: the table value, a name just given to an older slot of the same group, or a name given to the previous group.

Because the table is written one stage after it is read, a group never sees the mappings of the group directly ahead of it in the table. That group's names are bypassed instead. The free list starts with the upper half of the physical names, and the table starts as the identity map. Names freed at retirement come back through a commit port. A flush input squashes the group in the second stage, so that it is neither written nor bypassed.

Top module: `rename_pipe2`

## Requirements
- R1: After reset every architectural register r maps to physical name r, the free list holds names 64..127 in rising order, `in_ready_o` is high and `out_valid_o` is low.
- R2: A group accepted on a clock edge (in_valid_i and in_ready_o high) appears on the outputs, with `out_valid_o` high, during the following cycle only, unless it is flushed.
- R3: A source with no matching destination in an older slot of its own group or in the previous accepted group gets the name held in the table, which includes every group accepted two or more cycles before it.
- R4: A source that matches the destination of an older slot in its own group gets the physical name given to the youngest such slot.
- R5: A source with no match in its own group that matches a destination of the group accepted in the cycle just before it gets the name given to the youngest matching slot of that group.
- R6: The old mapping reported for a destination follows the same priority: youngest older writer in the same group, then youngest writer in the previous group, then the table.
- R7: When several slots of one group write the same architectural register, only the youngest one's name remains in the table.
- R8: Fresh names go, in free-list order, only to slots whose destination-valid bit is set, lowest slot first. A slot without a destination reports 0 as its new name and as its old mapping, and the names in one group are distinct.
- R9: `in_ready_o` is low whenever fewer than four names are free. A group offered while it is low is ignored, and no output appears for it.
- R10: Names on the commit port with their valid bit set join the free list tail in slot order, up to four per cycle. They are handed out after the names that were already free.
- R11: While `flush_i` is high, `out_valid_o` and `in_ready_o` are low. The group in the second stage is not written to the table and is not bypassed to the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Squash the group in the second stage |
| in_valid_i | input | 1 | A group of four instructions is offered |
| in_ready_o | output | 1 | A group can be accepted this cycle |
| in_src0_i | input | IW*AW | First source register of each slot, slot 0 in the low bits |
| in_src1_i | input | IW*AW | Second source register of each slot |
| in_dst_i | input | IW*AW | Destination register of each slot |
| in_dst_vld_i | input | IW | Slot has a destination |
| commit_vld_i | input | IW | Commit slot returns a name |
| commit_name_i | input | IW*PW | Returned physical names |
| out_valid_o | output | 1 | Renamed group is presented |
| out_src0_o | output | IW*PW | Physical name of first source per slot |
| out_src1_o | output | IW*PW | Physical name of second source per slot |
| out_pdst_o | output | IW*PW | New physical destination per slot |
| out_old_o | output | IW*PW | Previous mapping of each destination |
| out_dst_vld_o | output | IW | Slot has a destination |

## Verification
The hardest case to reach is a source that matches both an older slot of its own group and a slot of the previous group, while the table also holds a third, older name for the same register. Only a group driven on the very next edge after its producer, with no bubble between them, exercises the previous-group bypass. The directed tasks therefore send such groups back to back. They then insert exactly two idle cycles before a reader group, so that the same register is checked once through the bypass and once through the table. The flush task squashes a writer in the stage where it would otherwise be bypassed, and then reads the same register straight away.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int RNM_IW    = 4;
  localparam int RNM_NARCH = 64;
  localparam int RNM_NPHYS = 128;

  // Where the final name of an operand is taken from in stage 2.
  typedef enum logic [1:0] {
    SEL_TABLE = 2'd0,
    SEL_PREV  = 2'd1,
    SEL_CUR   = 2'd2
  } sel_src_e;
endpackage

// File: rtl/rnm_free_list.sv
// Circular FIFO of free physical names. NPHYS must be a power of two so
// that the pointers wrap naturally.
module rnm_free_list #(
  parameter int IW    = 4,
  parameter int NPHYS = 128,
  parameter int NARCH = 64,
  parameter int PW    = 7,
  parameter int CW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   alloc_i,
  input  logic [IW-1:0]          need_i,
  input  logic [IW-1:0]          rel_vld_i,
  input  logic [IW-1:0][PW-1:0]  rel_name_i,
  output logic                   avail_o,
  output logic [IW-1:0][PW-1:0]  name_o,
  output logic [CW-1:0]          count_o
);
  localparam int INIT = NPHYS - NARCH;

  logic [PW-1:0] mem_q [NPHYS];
  logic [PW-1:0] mem_d [NPHYS];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] count_q, count_d;
  logic [CW-1:0] pop_n, push_n;
  logic          upd;

  // Read side: slots needing a name take consecutive entries from head.
  always_comb begin
    pop_n = '0;
    for (int k = 0; k < IW; k++) begin
      name_o[k] = '0;
      if (need_i[k]) begin
        name_o[k] = mem_q[head_q + pop_n[PW-1:0]];
        pop_n     = pop_n + CW'(1);
      end
    end
  end

  // Write side: returned names are packed onto the tail in slot order.
  always_comb begin
    mem_d  = mem_q;
    push_n = '0;
    for (int k = 0; k < IW; k++) begin
      if (rel_vld_i[k]) begin
        mem_d[tail_q + push_n[PW-1:0]] = rel_name_i[k];
        push_n = push_n + CW'(1);
      end
    end
    head_d  = alloc_i ? head_q + pop_n[PW-1:0] : head_q;
    tail_d  = tail_q + push_n[PW-1:0];
    count_d = count_q - (alloc_i ? pop_n : '0) + push_n;
    upd     = alloc_i | (|rel_vld_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) begin
        mem_q[i] <= (i < INIT) ? PW'(NARCH + i) : '0;
      end
      head_q  <= '0;
      tail_q  <= PW'(INIT);
      count_q <= CW'(INIT);
    end else if (upd) begin
      mem_q   <= mem_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign avail_o = (count_q >= CW'(IW));
  assign count_o = count_q;
endmodule

// File: rtl/rnm_map_table.sv
// Architectural-to-physical alias table: many read ports, one write port
// per slot; a younger slot's write to the same entry overrides an older one.
module rnm_map_table #(
  parameter int IW    = 4,
  parameter int NARCH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7,
  parameter int NRD   = 12
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [NRD-1:0][AW-1:0] rd_addr_i,
  output logic [NRD-1:0][PW-1:0] rd_data_o,
  input  logic [IW-1:0]          wr_en_i,
  input  logic [IW-1:0][AW-1:0]  wr_addr_i,
  input  logic [IW-1:0][PW-1:0]  wr_data_i
);
  logic [PW-1:0] map_q [NARCH];
  logic [PW-1:0] map_d [NARCH];

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd_data_o[r] = map_q[rd_addr_i[r]];
    end
  end

  always_comb begin
    map_d = map_q;
    for (int j = 0; j < IW; j++) begin
      if (wr_en_i[j]) map_d[wr_addr_i[j]] = wr_data_i[j];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
    end else if (|wr_en_i) begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/rnm_dep_check.sv
// Stage-1 comparator set for one operand: up to OLDER current-group
// destinations and IW previous-group destinations; the nearest producer wins.
module rnm_dep_check
  import rnm_pkg::*;
#(
  parameter int IW    = 4,
  parameter int AW    = 6,
  parameter int IDW   = 2,
  parameter int OLDER = 0
) (
  input  logic [AW-1:0]          arch_i,
  input  logic [IW-1:0][AW-1:0]  cur_dst_i,
  input  logic [IW-1:0]          cur_dv_i,
  input  logic [IW-1:0][AW-1:0]  prv_dst_i,
  input  logic [IW-1:0]          prv_dv_i,
  output sel_src_e               kind_o,
  output logic [IDW-1:0]         idx_o
);
  always_comb begin
    kind_o = SEL_TABLE;
    idx_o  = '0;
    // Previous group first so that any current-group hit overrides it;
    // within each group the later (younger) slot overrides.
    for (int j = 0; j < IW; j++) begin
      if (prv_dv_i[j] && (prv_dst_i[j] == arch_i)) begin
        kind_o = SEL_PREV;
        idx_o  = IDW'(j);
      end
    end
    for (int j = 0; j < IW; j++) begin
      if ((j < OLDER) && cur_dv_i[j] && (cur_dst_i[j] == arch_i)) begin
        kind_o = SEL_CUR;
        idx_o  = IDW'(j);
      end
    end
  end
endmodule

// File: rtl/rnm_final_sel.sv
// Stage-2 output multiplexer for one operand.
module rnm_final_sel
  import rnm_pkg::*;
#(
  parameter int IW  = 4,
  parameter int PW  = 7,
  parameter int IDW = 2
) (
  input  sel_src_e              kind_i,
  input  logic [IDW-1:0]        idx_i,
  input  logic [PW-1:0]         tbl_i,
  input  logic [IW-1:0][PW-1:0] cur_i,
  input  logic [IW-1:0][PW-1:0] prv_i,
  output logic [PW-1:0]         name_o
);
  always_comb begin
    unique case (kind_i)
      SEL_CUR:  name_o = cur_i[idx_i];
      SEL_PREV: name_o = prv_i[idx_i];
      default:  name_o = tbl_i;
    endcase
  end
endmodule

// File: rtl/rename_pipe2.sv
module rename_pipe2
  import rnm_pkg::*;
#(
  parameter int IW    = RNM_IW,
  parameter int NARCH = RNM_NARCH,
  parameter int NPHYS = RNM_NPHYS,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IW*AW-1:0] in_src0_i,
  input  logic [IW*AW-1:0] in_src1_i,
  input  logic [IW*AW-1:0] in_dst_i,
  input  logic [IW-1:0]    in_dst_vld_i,
  input  logic [IW-1:0]    commit_vld_i,
  input  logic [IW*PW-1:0] commit_name_i,
  output logic             out_valid_o,
  output logic [IW*PW-1:0] out_src0_o,
  output logic [IW*PW-1:0] out_src1_o,
  output logic [IW*PW-1:0] out_pdst_o,
  output logic [IW*PW-1:0] out_old_o,
  output logic [IW-1:0]    out_dst_vld_o
);
  localparam int IDW = (IW > 1) ? $clog2(IW) : 1;
  localparam int CW  = PW + 1;
  localparam int NRD = 3 * IW;

  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // ---------------- stage 1: decode, compare, allocate ----------------
  logic [IW-1:0][AW-1:0] a_src0, a_src1, a_dst;
  logic [IW-1:0][PW-1:0] rel_name;
  logic [IW-1:0][PW-1:0] new_name;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][PW-1:0] rd_data;
  sel_src_e              k_src0 [IW];
  sel_src_e              k_src1 [IW];
  sel_src_e              k_dst  [IW];
  logic [IDW-1:0]        i_src0 [IW];
  logic [IDW-1:0]        i_src1 [IW];
  logic [IDW-1:0]        i_dst  [IW];
  logic                  fl_avail;
  logic [CW-1:0]         fl_count;
  logic                  accept;

  // stage-2 state
  logic                  s2_vld_q;
  logic [IW-1:0][AW-1:0] s2_dst_q;
  logic [IW-1:0]         s2_dv_q;
  logic [IW-1:0][PW-1:0] s2_pdst_q;
  logic [IW-1:0][PW-1:0] s2_prev_q;
  sel_src_e              s2_k0_q [IW];
  sel_src_e              s2_k1_q [IW];
  sel_src_e              s2_kd_q [IW];
  logic [IDW-1:0]        s2_i0_q [IW];
  logic [IDW-1:0]        s2_i1_q [IW];
  logic [IDW-1:0]        s2_id_q [IW];
  logic [PW-1:0]         s2_t0_q [IW];
  logic [PW-1:0]         s2_t1_q [IW];
  logic [PW-1:0]         s2_td_q [IW];
  logic [IW-1:0]         prv_dv;

  assign in_ready_o = fl_avail & ~flush_i & rst_n_int;
  assign accept     = in_valid_i & in_ready_o;
  assign prv_dv     = s2_dv_q & {IW{s2_vld_q}};

  for (genvar k = 0; k < IW; k++) begin : g_slot
    assign a_src0[k]      = in_src0_i[k*AW +: AW];
    assign a_src1[k]      = in_src1_i[k*AW +: AW];
    assign a_dst[k]       = in_dst_i[k*AW +: AW];
    assign rel_name[k]    = commit_name_i[k*PW +: PW];
    assign rd_addr[3*k]   = a_src0[k];
    assign rd_addr[3*k+1] = a_src1[k];
    assign rd_addr[3*k+2] = a_dst[k];

    rnm_dep_check #(.IW(IW), .AW(AW), .IDW(IDW), .OLDER(k)) u_dep_s0 (
      .arch_i(a_src0[k]), .cur_dst_i(a_dst), .cur_dv_i(in_dst_vld_i),
      .prv_dst_i(s2_dst_q), .prv_dv_i(prv_dv),
      .kind_o(k_src0[k]), .idx_o(i_src0[k]));

    rnm_dep_check #(.IW(IW), .AW(AW), .IDW(IDW), .OLDER(k)) u_dep_s1 (
      .arch_i(a_src1[k]), .cur_dst_i(a_dst), .cur_dv_i(in_dst_vld_i),
      .prv_dst_i(s2_dst_q), .prv_dv_i(prv_dv),
      .kind_o(k_src1[k]), .idx_o(i_src1[k]));

    rnm_dep_check #(.IW(IW), .AW(AW), .IDW(IDW), .OLDER(k)) u_dep_dst (
      .arch_i(a_dst[k]), .cur_dst_i(a_dst), .cur_dv_i(in_dst_vld_i),
      .prv_dst_i(s2_dst_q), .prv_dv_i(prv_dv),
      .kind_o(k_dst[k]), .idx_o(i_dst[k]));
  end

  rnm_free_list #(.IW(IW), .NPHYS(NPHYS), .NARCH(NARCH), .PW(PW), .CW(CW)) u_free (
    .clk(clk), .rst_ni(rst_n_int),
    .alloc_i(accept), .need_i(in_dst_vld_i),
    .rel_vld_i(commit_vld_i), .rel_name_i(rel_name),
    .avail_o(fl_avail), .name_o(new_name), .count_o(fl_count));

  // ---------------- alias table ----------------
  logic [IW-1:0]         wr_en;

  assign wr_en = s2_dv_q & {IW{s2_vld_q & ~flush_i}};

  rnm_map_table #(.IW(IW), .NARCH(NARCH), .AW(AW), .PW(PW), .NRD(NRD)) u_table (
    .clk(clk), .rst_ni(rst_n_int),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(s2_dst_q), .wr_data_i(s2_pdst_q));

  // ---------------- stage-1 / stage-2 boundary registers ----------------
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      s2_vld_q <= 1'b0;
    end else begin
      s2_vld_q <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      s2_dst_q  <= '0;
      s2_dv_q   <= '0;
      s2_pdst_q <= '0;
      s2_prev_q <= '0;
      for (int k = 0; k < IW; k++) begin
        s2_k0_q[k] <= SEL_TABLE;
        s2_k1_q[k] <= SEL_TABLE;
        s2_kd_q[k] <= SEL_TABLE;
        s2_i0_q[k] <= '0;
        s2_i1_q[k] <= '0;
        s2_id_q[k] <= '0;
      end
    end else if (accept) begin
      s2_dst_q  <= a_dst;
      s2_dv_q   <= in_dst_vld_i;
      s2_pdst_q <= new_name;
      s2_prev_q <= s2_pdst_q;
      for (int k = 0; k < IW; k++) begin
        s2_k0_q[k] <= k_src0[k];
        s2_k1_q[k] <= k_src1[k];
        s2_kd_q[k] <= k_dst[k];
        s2_i0_q[k] <= i_src0[k];
        s2_i1_q[k] <= i_src1[k];
        s2_id_q[k] <= i_dst[k];
      end
    end
  end

  // Table read latches: enabled only when no comparator hit (NOR gate of
  // the compare results), so an unneeded read never toggles the latch.
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      for (int k = 0; k < IW; k++) begin
        s2_t0_q[k] <= '0;
        s2_t1_q[k] <= '0;
        s2_td_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < IW; k++) begin
        if (accept && (k_src0[k] == SEL_TABLE)) s2_t0_q[k] <= rd_data[3*k];
        if (accept && (k_src1[k] == SEL_TABLE)) s2_t1_q[k] <= rd_data[3*k+1];
        if (accept && (k_dst[k]  == SEL_TABLE)) s2_td_q[k] <= rd_data[3*k+2];
      end
    end
  end

  // ---------------- stage 2: final selection ----------------
  for (genvar k = 0; k < IW; k++) begin : g_out
    logic [PW-1:0] n0, n1, nd;

    rnm_final_sel #(.IW(IW), .PW(PW), .IDW(IDW)) u_sel_s0 (
      .kind_i(s2_k0_q[k]), .idx_i(s2_i0_q[k]), .tbl_i(s2_t0_q[k]),
      .cur_i(s2_pdst_q), .prv_i(s2_prev_q), .name_o(n0));

    rnm_final_sel #(.IW(IW), .PW(PW), .IDW(IDW)) u_sel_s1 (
      .kind_i(s2_k1_q[k]), .idx_i(s2_i1_q[k]), .tbl_i(s2_t1_q[k]),
      .cur_i(s2_pdst_q), .prv_i(s2_prev_q), .name_o(n1));

    rnm_final_sel #(.IW(IW), .PW(PW), .IDW(IDW)) u_sel_dst (
      .kind_i(s2_kd_q[k]), .idx_i(s2_id_q[k]), .tbl_i(s2_td_q[k]),
      .cur_i(s2_pdst_q), .prv_i(s2_prev_q), .name_o(nd));

    assign out_src0_o[k*PW +: PW] = n0;
    assign out_src1_o[k*PW +: PW] = n1;
    assign out_pdst_o[k*PW +: PW] = s2_pdst_q[k];
    assign out_old_o[k*PW +: PW]  = s2_dv_q[k] ? nd : '0;
  end

  assign out_valid_o   = s2_vld_q & ~flush_i;
  assign out_dst_vld_o = s2_dv_q;
endmodule

// File: rtl/rename_pipe2_chk.sv
module rename_pipe2_chk #(
  parameter int IW    = 4,
  parameter int AW    = 6,
  parameter int PW    = 7,
  parameter int CW    = 8,
  parameter int NPHYS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IW*AW-1:0] in_src0,
  input logic [IW*AW-1:0] in_dst,
  input logic [IW-1:0]    in_dv,
  input logic             out_valid,
  input logic [IW*PW-1:0] out_src0,
  input logic [IW*PW-1:0] out_pdst,
  input logic [IW-1:0]    out_dv,
  input logic [CW-1:0]    fl_count
);
  assert_ready_needs_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count < CW'(IW)) |-> !in_ready);

  assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid || flush));

  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !in_ready));

  assert_free_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= CW'(NPHYS));

  for (genvar k = 0; k < IW; k++) begin : g_k
    assert_nodst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_dv[k]) |-> (out_pdst[k*PW +: PW] == '0));

    for (genvar j = 0; j < k; j++) begin : g_j
      assert_unique_pdst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dv[k] && out_dv[j]) |->
          (out_pdst[k*PW +: PW] != out_pdst[j*PW +: PW]));
    end

    if (k > 0) begin : g_adj
      assert_adjacent_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dv[k-1] &&
         (in_src0[k*AW +: AW] == in_dst[(k-1)*AW +: AW]))
        |=> (flush || (out_src0[k*PW +: PW] == out_pdst[(k-1)*PW +: PW])));
    end
  end
endmodule

bind rename_pipe2 rename_pipe2_chk #(
  .IW(IW), .AW(AW), .PW(PW), .CW(CW), .NPHYS(NPHYS)
) u_chk (
  .clk(clk), .rst_n(rst_n_int), .flush(flush_i),
  .in_valid(in_valid_i), .in_ready(in_ready_o),
  .in_src0(in_src0_i), .in_dst(in_dst_i), .in_dv(in_dst_vld_i),
  .out_valid(out_valid_o), .out_src0(out_src0_o), .out_pdst(out_pdst_o),
  .out_dv(out_dst_vld_o), .fl_count(fl_count)
);

// File: tb/test_rename_pipe2.sv
`timescale 1ns/1ps
module test_rename_pipe2;
  localparam int IW = 4;
  localparam int AW = 6;
  localparam int PW = 7;
  localparam int NARCH = 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush_i;
  logic             in_valid_i;
  logic             in_ready_o;
  logic [IW*AW-1:0] in_src0_i, in_src1_i, in_dst_i;
  logic [IW-1:0]    in_dst_vld_i;
  logic [IW-1:0]    commit_vld_i;
  logic [IW*PW-1:0] commit_name_i;
  logic             out_valid_o;
  logic [IW*PW-1:0] out_src0_o, out_src1_o, out_pdst_o, out_old_o;
  logic [IW-1:0]    out_dst_vld_o;

  rename_pipe2 i_rename_pipe2 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_src0_i(in_src0_i), .in_src1_i(in_src1_i), .in_dst_i(in_dst_i),
    .in_dst_vld_i(in_dst_vld_i), .commit_vld_i(commit_vld_i),
    .commit_name_i(commit_name_i), .out_valid_o(out_valid_o),
    .out_src0_o(out_src0_o), .out_src1_o(out_src1_o), .out_pdst_o(out_pdst_o),
    .out_old_o(out_old_o), .out_dst_vld_o(out_dst_vld_o));

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;

  // Reference state derived from the requirements (sequential renaming).
  int rmap [NARCH];
  int rmap_snap [NARCH];
  int fl [$];
  int rel [$];

  // Stimulus of the next group.
  int g_s0 [IW];
  int g_s1 [IW];
  int g_d  [IW];
  bit g_dv [IW];

  // Expected outputs of the group now in stage 2.
  bit    exp_pend = 1'b0;
  string exp_tag;
  int    e_s0 [IW];
  int    e_s1 [IW];
  int    e_pd [IW];
  int    e_old [IW];
  bit    e_dv [IW];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_group(input int s0 [IW], input int s1 [IW], input int d [IW], input bit dv [IW]);
    for (int k = 0; k < IW; k++) begin
      g_s0[k] = s0[k]; g_s1[k] = s1[k]; g_d[k] = d[k]; g_dv[k] = dv[k];
    end
  endtask

  // One clock cycle, entered and left at a falling edge.
  task automatic step(input bit v, input bit fl_, input string tag);
    bit exp_rdy;
    in_valid_i = v;
    flush_i    = fl_;
    for (int k = 0; k < IW; k++) begin
      in_src0_i[k*AW +: AW] = AW'(g_s0[k]);
      in_src1_i[k*AW +: AW] = AW'(g_s1[k]);
      in_dst_i[k*AW +: AW]  = AW'(g_d[k]);
      in_dst_vld_i[k]       = g_dv[k];
      commit_vld_i[k]       = 1'b0;
      commit_name_i[k*PW +: PW] = '0;
    end
    for (int k = 0; k < IW && k < rel.size(); k++) begin
      commit_vld_i[k] = 1'b1;
      commit_name_i[k*PW +: PW] = PW'(rel[k]);
    end
    #1;
    if (exp_pend && !fl_) begin
      chk(exp_tag, "out_valid", int'(out_valid_o), 1);
      for (int k = 0; k < IW; k++) begin
        chk(exp_tag, $sformatf("slot%0d src0", k), int'(out_src0_o[k*PW +: PW]), e_s0[k]);
        chk(exp_tag, $sformatf("slot%0d src1", k), int'(out_src1_o[k*PW +: PW]), e_s1[k]);
        chk(exp_tag, $sformatf("slot%0d pdst", k), int'(out_pdst_o[k*PW +: PW]), e_pd[k]);
        chk(exp_tag, $sformatf("slot%0d old", k), int'(out_old_o[k*PW +: PW]), e_old[k]);
      end
    end else begin
      chk(tag, "out_valid idle/flushed", int'(out_valid_o), 0);
      if (exp_pend && fl_) begin
        for (int r = 0; r < NARCH; r++) rmap[r] = rmap_snap[r];
      end
    end
    exp_pend = 1'b0;
    exp_rdy  = (fl.size() >= IW) && !fl_;
    chk(tag, "in_ready", int'(in_ready_o), int'(exp_rdy));
    if (v && exp_rdy) begin
      for (int r = 0; r < NARCH; r++) rmap_snap[r] = rmap[r];
      for (int k = 0; k < IW; k++) begin
        e_s0[k] = rmap[g_s0[k]];
        e_s1[k] = rmap[g_s1[k]];
        e_dv[k] = g_dv[k];
        if (g_dv[k]) begin
          e_old[k] = rmap[g_d[k]];
          e_pd[k]  = fl.pop_front();
          rmap[g_d[k]] = e_pd[k];
        end else begin
          e_old[k] = 0;
          e_pd[k]  = 0;
        end
      end
      exp_pend = 1'b1;
      exp_tag  = tag;
    end
    for (int k = 0; k < IW && rel.size() > 0; k++) fl.push_back(rel.pop_front());
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    flush_i    = 1'b0;
    commit_vld_i = '0;
  endtask

  task automatic t_reset_r1();
    #1;
    chk("R1", "out_valid after reset", int'(out_valid_o), 0);
    chk("R1", "in_ready after reset", int'(in_ready_o), 1);
    set_group('{10, 11, 12, 13}, '{20, 21, 22, 23}, '{1, 2, 3, 4}, '{1, 1, 1, 1});
    step(1, 0, "R1");
    step(0, 0, "R2");
    step(0, 0, "R2");
  endtask

  task automatic t_intra_r4();
    set_group('{0, 5, 5, 6}, '{1, 9, 5, 5}, '{5, 5, 6, 7}, '{1, 1, 1, 1});
    step(1, 0, "R4");
    step(0, 0, "R4");
  endtask

  task automatic t_inter_r5();
    set_group('{2, 3, 4, 0}, '{3, 2, 1, 0}, '{8, 9, 8, 10}, '{1, 1, 1, 1});
    step(1, 0, "R5");
    set_group('{8, 10, 9, 9}, '{9, 8, 8, 10}, '{11, 9, 12, 13}, '{1, 1, 0, 1});
    step(1, 0, "R5");
    step(0, 0, "R5");
  endtask

  task automatic t_table_r3();
    set_group('{0, 0, 0, 0}, '{0, 0, 0, 0}, '{14, 15, 16, 17}, '{1, 0, 0, 0});
    step(1, 0, "R3");
    set_group('{0, 0, 0, 0}, '{0, 0, 0, 0}, '{18, 15, 16, 17}, '{1, 0, 0, 0});
    step(1, 0, "R3");
    set_group('{14, 18, 14, 1}, '{18, 14, 5, 8}, '{19, 14, 16, 17}, '{0, 1, 0, 0});
    step(1, 0, "R3");
    step(0, 0, "R3");
  endtask

  task automatic t_waw_r6_r7();
    set_group('{0, 0, 0, 0}, '{0, 0, 0, 0}, '{20, 20, 21, 20}, '{1, 1, 1, 1});
    step(1, 0, "R6");
    set_group('{20, 21, 20, 0}, '{0, 0, 0, 0}, '{20, 21, 22, 20}, '{1, 1, 0, 1});
    step(1, 0, "R6");
    step(0, 0, "R7");
    step(0, 0, "R7");
    set_group('{20, 21, 22, 20}, '{21, 20, 20, 21}, '{0, 0, 0, 0}, '{0, 0, 0, 0});
    step(1, 0, "R7");
    step(0, 0, "R7");
  endtask

  task automatic t_nodst_r8();
    set_group('{23, 24, 25, 26}, '{24, 25, 26, 23}, '{23, 24, 25, 26}, '{0, 1, 0, 1});
    step(1, 0, "R8");
    set_group('{24, 26, 0, 0}, '{0, 0, 0, 0}, '{27, 28, 29, 30}, '{0, 0, 1, 0});
    step(1, 0, "R8");
    step(0, 0, "R8");
  endtask

  task automatic t_flush_r11();
    set_group('{0, 0, 0, 0}, '{0, 0, 0, 0}, '{40, 41, 42, 43}, '{1, 1, 0, 0});
    step(1, 0, "R11");
    step(0, 1, "R11");
    set_group('{40, 41, 42, 40}, '{41, 40, 0, 0}, '{40, 42, 43, 44}, '{1, 0, 0, 0});
    step(1, 0, "R11");
    step(0, 0, "R11");
  endtask

  task automatic t_stall_r9_r10();
    int guard = 0;
    set_group('{30, 31, 32, 33}, '{33, 32, 31, 30}, '{30, 31, 32, 33}, '{1, 1, 1, 1});
    while (fl.size() >= IW && guard < 40) begin
      step(1, 0, "R9");
      guard++;
    end
    step(1, 0, "R9");    // offered while not ready: must be ignored
    step(0, 0, "R9");    // no output may appear
    rel.push_back(3); rel.push_back(5); rel.push_back(7); rel.push_back(9);
    step(0, 0, "R10");
    set_group('{30, 31, 1, 2}, '{0, 0, 0, 0}, '{50, 51, 52, 53}, '{1, 1, 1, 1});
    step(1, 0, "R10");
    step(0, 0, "R10");
  endtask

  initial begin
    #1_200_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NARCH; r++) rmap[r] = r;
    for (int p = 64; p < 128; p++) fl.push_back(p);
    for (int k = 0; k < IW; k++) begin
      g_s0[k] = 0; g_s1[k] = 0; g_d[k] = 0; g_dv[k] = 0;
    end
    rst_n = 1'b0; flush_i = 1'b0; in_valid_i = 1'b0;
    in_src0_i = '0; in_src1_i = '0; in_dst_i = '0; in_dst_vld_i = '0;
    commit_vld_i = '0; commit_name_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_intra_r4();
    t_inter_r5();
    t_table_r3();
    t_waw_r6_r7();
    t_nodst_r8();
    t_flush_r11();
    t_stall_r9_r10();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule